// File: doc/BRIEF.md
# RGB Panel Pixel Output Stage

This block is the last stage before a parallel RGB LCD panel. It takes a stream of 24-bit pixels (8 bits each of red, green and blue) and drives three 8-bit colour buses together with a panel pixel clock. The pixel clock comes from the system clock through a programmable integer divisor. A divisor of zero turns the pixel clock off. A polarity bit chooses which pixel clock edge is the active one.

Every pixel goes through three steps. First, each channel is reduced to its own programmed precision, with an optional 4x4 ordered dither applied before truncation. Second, a swizzle stage can swap red with blue, rotate the channel triple and reverse the bit order, so that the board can route to any panel pin arrangement. Third, an optional stagger mode spreads the output switching: the red pins change one pixel period before the green pins, and the blue pins change one period after them.

The block asks for a pixel with `pix_req`, once per pixel clock period. The pixel present on `pix_data` in that cycle is taken in. The dither position comes from the low bits of the pixel column and row counters, which are supplied by the timing logic outside the block.

Top module: `rgb_pixel_out`

## Requirements
- R1: For a divisor D with 2 <= D <= 1023 and polarity 0, `pix_req` is high for exactly one system cycle in every D cycles. `pclk` rises at the system edge that ends a request cycle and stays high for ceil(D/2) system cycles of each D-cycle period.
- R2: With a divisor of 0, the reset value, `pclk` holds a constant level equal to the polarity bit. `pix_req` stays low, and the colour outputs keep their values whatever `pix_data` does.
- R3: Polarity 1 inverts `pclk`, so that the active edge is the falling edge. The divisor behaviour is otherwise unchanged.
- R4: With a divisor of 1, `pclk` is the system clock (inverted when the polarity is 1) and `pix_req` is high in every cycle.
- R5: The pixel on `pix_data` in a cycle with `pix_req` high is taken in at the next system edge, which is the active `pclk` edge. The colour pins change only at such edges and hold between them.
- R6: With the stagger bit at 0, all three colour buses show the pixel accepted at the latest request.
- R7: With the stagger bit at 1, the red pins show pixel k, the green pins show pixel k-1 and the blue pins show pixel k-2 after the k-th accepted pixel, counting pins after swizzling.
- R8: `cfg_width` holds three 3-bit fields: bits [2:0] for red, [5:3] for green and [8:6] for blue, where `pix_data` carries red in [23:16], green in [15:8] and blue in [7:0]. A field value n from 1 to 7 keeps the top n bits and drives the dropped low bits to zero. The value 0 means 8 bits. All of this happens before swizzling.
- R9: With `cfg_dither` at 1 and d = 8 - width > 0, the threshold T at row `pix_y` and column `pix_x` is taken from rows {0,8,2,10}, {12,4,14,6}, {3,11,1,9}, {15,7,13,5}. The value floor(T*2^d/16) is added to the channel before truncation, and the sum saturates at 255.
- R10: `cfg_swz` bit 1 swaps the red and blue channels before any rotation.
- R11: With `cfg_swz` bit 3 set, the red, green and blue pins carry the (swapped) blue, red and green channels when bit 2 is 0, and the green, blue and red channels when bit 2 is 1.
- R12: `cfg_swz` bit 0 reverses the bit order of every output bus after swap and rotation, so that pin 7 carries bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 10 | Pixel clock divisor; 0 disables the pixel clock |
| cfg_pol | input | 1 | Active edge select: 0 rising, 1 falling |
| cfg_spread | input | 1 | Staggered channel output enable |
| cfg_dither | input | 1 | Ordered dither enable |
| cfg_width | input | 9 | Per-channel output width fields |
| cfg_swz | input | 4 | Pin swizzle: reverse, swap, rotate direction, rotate enable |
| pix_data | input | 24 | Pixel in; red, green and blue from the top byte down |
| pix_x | input | 2 | Low bits of the pixel column |
| pix_y | input | 2 | Low bits of the pixel row |
| pix_req | output | 1 | Pixel request; data is taken in this cycle |
| pclk | output | 1 | Panel pixel clock |
| r_out | output | 8 | Red pins |
| g_out | output | 8 | Green pins |
| b_out | output | 8 | Blue pins |

## Verification
On every cycle the assertions check the following: the pixel clock stays still and no request is raised while the divisor is zero; requests with a divisor of two or more last a single cycle; a divisor of one requests on every cycle; and the colour pins move only after a request cycle. The colour values themselves are left to the bench. It sweeps every swizzle code, every width field with dither on and off at all sixteen dither positions, and a staggered pixel sequence, and compares each result with an arithmetic model. The bench also counts pixel clock high phases and requests for several divisors and both polarities, and checks the system-clock follow mode.

// File: rtl/rgb_out_pkg.sv
`timescale 1ns/1ps
package rgb_out_pkg;

   typedef struct packed {
      logic rot_en;
      logic rot_back;
      logic swap_rb;
      logic rev_bits;
   } swz_cfg_t;

   typedef enum logic [1:0] {
      ROT_NONE = 2'd0,
      ROT_FWD  = 2'd1,
      ROT_BACK = 2'd2
   } rot_mode_e;

   // 4x4 ordered threshold built from two interleaved 2x2 levels
   function automatic logic [3:0] dither_thresh(input logic [1:0] px, input logic [1:0] py);
      return {px[0] ^ py[0], py[0], px[1] ^ py[1], py[1]};
   endfunction

endpackage

// File: rtl/rgb_pclk_gen.sv
`timescale 1ns/1ps
module rgb_pclk_gen #(
   parameter int unsigned DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             pol,
   output logic             tick,
   output logic             pclk
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] cnt_nxt;
   logic [DIV_W:0]   hi_len;
   logic             div_zero;
   logic             div_one;
   logic             level_nxt;
   logic             pclk_q;

   always_comb begin
      div_zero  = (div == '0);
      div_one   = (div == DIV_W'(1));
      tick      = !div_zero && (cnt >= (div - DIV_W'(1)));
      cnt_nxt   = (div_zero || tick) ? '0 : cnt + DIV_W'(1);
      hi_len    = ({1'b0, div} + (DIV_W+1)'(1)) >> 1;
      level_nxt = !div_zero && ({1'b0, cnt_nxt} < hi_len);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         pclk_q <= 1'b0;
      end else begin
         cnt    <= cnt_nxt;
         pclk_q <= level_nxt;
      end
   end

   // divisor of one: system clock gated by the always-true enable
   assign pclk = (div_one ? (clk & tick) : pclk_q) ^ pol;

endmodule

// File: rtl/rgb_chan_prep.sv
`timescale 1ns/1ps
module rgb_chan_prep
   import rgb_out_pkg::*;
#(
   parameter int unsigned CH_W   = 8,
   parameter int unsigned WSEL_W = 3
) (
   input  logic [CH_W-1:0]   din,
   input  logic [WSEL_W-1:0] wsel,
   input  logic              dither_en,
   input  logic [1:0]        pos_x,
   input  logic [1:0]        pos_y,
   output logic [CH_W-1:0]   dout
);

   localparam int unsigned EW = CH_W + 5;

   logic [WSEL_W:0] keep;
   logic [WSEL_W:0] drop;
   logic [EW-1:0]   th_w;
   logic [EW-1:0]   scaled;
   logic [EW-1:0]   sum_w;
   logic [CH_W-1:0] sat_v;
   logic [CH_W-1:0] mask;

   always_comb begin
      keep   = (wsel == '0) ? (WSEL_W+1)'(CH_W) : {1'b0, wsel};
      drop   = (WSEL_W+1)'(CH_W) - keep;
      th_w   = EW'(dither_thresh(pos_x, pos_y));
      // align the 4-bit threshold with the top of the dropped bits
      scaled = (th_w << drop) >> 4;
      sum_w  = EW'(din) + ((dither_en && (drop != '0)) ? scaled : '0);
      sat_v  = (sum_w > EW'({CH_W{1'b1}})) ? '1 : sum_w[CH_W-1:0];
      mask   = {CH_W{1'b1}} << drop;
      dout   = sat_v & mask;
   end

endmodule

// File: rtl/rgb_swizzle.sv
`timescale 1ns/1ps
module rgb_swizzle
   import rgb_out_pkg::*;
#(
   parameter int unsigned CH_W = 8
) (
   input  logic [CH_W-1:0] in_r,
   input  logic [CH_W-1:0] in_g,
   input  logic [CH_W-1:0] in_b,
   input  logic [3:0]      swz,
   output logic [CH_W-1:0] out_r,
   output logic [CH_W-1:0] out_g,
   output logic [CH_W-1:0] out_b
);

   swz_cfg_t        s;
   rot_mode_e       mode;
   logic [CH_W-1:0] ca, cb, cc;
   logic [CH_W-1:0] pa, pb, pc;

   assign s = swz_cfg_t'(swz);

   always_comb begin
      if (!s.rot_en)        mode = ROT_NONE;
      else if (s.rot_back)  mode = ROT_BACK;
      else                  mode = ROT_FWD;
      ca = s.swap_rb ? in_b : in_r;
      cb = in_g;
      cc = s.swap_rb ? in_r : in_b;
      unique case (mode)
         ROT_FWD:  {pa, pb, pc} = {cc, ca, cb};
         ROT_BACK: {pa, pb, pc} = {cb, cc, ca};
         default:  {pa, pb, pc} = {ca, cb, cc};
      endcase
   end

   for (genvar i = 0; i < CH_W; i++) begin : g_bit
      assign out_r[i] = s.rev_bits ? pa[CH_W-1-i] : pa[i];
      assign out_g[i] = s.rev_bits ? pb[CH_W-1-i] : pb[i];
      assign out_b[i] = s.rev_bits ? pc[CH_W-1-i] : pc[i];
   end

endmodule

// File: rtl/rgb_stagger.sv
`timescale 1ns/1ps
module rgb_stagger #(
   parameter int unsigned CH_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            spread,
   input  logic [CH_W-1:0] in_r,
   input  logic [CH_W-1:0] in_g,
   input  logic [CH_W-1:0] in_b,
   output logic [CH_W-1:0] out_r,
   output logic [CH_W-1:0] out_g,
   output logic [CH_W-1:0] out_b
);

   logic [CH_W-1:0] g_d1;
   logic [CH_W-1:0] b_d1;
   logic [CH_W-1:0] b_d2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_r <= '0;
         out_g <= '0;
         out_b <= '0;
         g_d1  <= '0;
         b_d1  <= '0;
         b_d2  <= '0;
      end else if (load) begin
         g_d1  <= in_g;
         b_d1  <= in_b;
         b_d2  <= b_d1;
         out_r <= in_r;
         out_g <= spread ? g_d1 : in_g;
         out_b <= spread ? b_d2 : in_b;
      end
   end

endmodule

// File: rtl/rgb_pixel_out.sv
`timescale 1ns/1ps
module rgb_pixel_out #(
   parameter int unsigned DIV_W = 10,
   parameter int unsigned CH_W  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DIV_W-1:0]            cfg_div,
   input  logic                        cfg_pol,
   input  logic                        cfg_spread,
   input  logic                        cfg_dither,
   input  logic [3*$clog2(CH_W)-1:0]   cfg_width,
   input  logic [3:0]                  cfg_swz,
   input  logic [3*CH_W-1:0]           pix_data,
   input  logic [1:0]                  pix_x,
   input  logic [1:0]                  pix_y,
   output logic                        pix_req,
   output logic                        pclk,
   output logic [CH_W-1:0]             r_out,
   output logic [CH_W-1:0]             g_out,
   output logic [CH_W-1:0]             b_out
);

   localparam int unsigned WSEL_W = $clog2(CH_W);
   localparam int unsigned NCH    = 3;

   if (CH_W < 4 || (1 << WSEL_W) != CH_W) begin : g_bad_ch
      $error("CH_W must be a power of two of at least 4");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end

   logic            tick;
   logic [CH_W-1:0] prep [NCH];
   logic [CH_W-1:0] sw_r, sw_g, sw_b;

   rgb_pclk_gen #(.DIV_W(DIV_W)) i_pclk (
      .clk   (clk),
      .rst_n (rst_n),
      .div   (cfg_div),
      .pol   (cfg_pol),
      .tick  (tick),
      .pclk  (pclk)
   );

   assign pix_req = tick;

   // channel 0 is red (top slice), 2 is blue (bottom slice)
   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      rgb_chan_prep #(.CH_W(CH_W), .WSEL_W(WSEL_W)) i_prep (
         .din       (pix_data[(NCH-1-ch)*CH_W +: CH_W]),
         .wsel      (cfg_width[ch*WSEL_W +: WSEL_W]),
         .dither_en (cfg_dither),
         .pos_x     (pix_x),
         .pos_y     (pix_y),
         .dout      (prep[ch])
      );
   end

   rgb_swizzle #(.CH_W(CH_W)) i_swz (
      .in_r  (prep[0]),
      .in_g  (prep[1]),
      .in_b  (prep[2]),
      .swz   (cfg_swz),
      .out_r (sw_r),
      .out_g (sw_g),
      .out_b (sw_b)
   );

   rgb_stagger #(.CH_W(CH_W)) i_stg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (tick),
      .spread (cfg_spread),
      .in_r   (sw_r),
      .in_g   (sw_g),
      .in_b   (sw_b),
      .out_r  (r_out),
      .out_g  (g_out),
      .out_b  (b_out)
   );

endmodule

// File: rtl/rgb_pixel_out_chk.sv
`timescale 1ns/1ps
module rgb_pixel_out_chk #(
   parameter int unsigned DIV_W = 10,
   parameter int unsigned CH_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] cfg_div,
   input logic             cfg_pol,
   input logic             pix_req,
   input logic             pclk,
   input logic [CH_W-1:0]  r_out,
   input logic [CH_W-1:0]  g_out,
   input logic [CH_W-1:0]  b_out
);

   a_r2_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_div == '0) |-> !pix_req);

   a_r2_pclk_static: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_div == '0 && $past(cfg_div) == '0 && $past(cfg_div, 2) == '0 && $stable(cfg_pol))
      |-> $stable(pclk));

   a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_div >= DIV_W'(2) && pix_req) |=> (cfg_div < DIV_W'(2) || !pix_req));

   a_r4_req_every: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_div == DIV_W'(1)) |-> pix_req);

   a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pix_req) |-> ($stable(r_out) && $stable(g_out) && $stable(b_out)));

endmodule

bind rgb_pixel_out rgb_pixel_out_chk #(.DIV_W(DIV_W), .CH_W(CH_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_div (cfg_div),
   .cfg_pol (cfg_pol),
   .pix_req (pix_req),
   .pclk    (pclk),
   .r_out   (r_out),
   .g_out   (g_out),
   .b_out   (b_out)
);

// File: tb/test_rgb_pixel_out.sv
`timescale 1ns/1ps
module test_rgb_pixel_out;

   localparam int BT [16] = '{0, 8, 2, 10, 12, 4, 14, 6, 3, 11, 1, 9, 15, 7, 13, 5};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  cfg_div = '0;
   logic        cfg_pol = 1'b0;
   logic        cfg_spread = 1'b0;
   logic        cfg_dither = 1'b0;
   logic [8:0]  cfg_width = '0;
   logic [3:0]  cfg_swz = '0;
   logic [23:0] pix_data = '0;
   logic [1:0]  pix_x = '0;
   logic [1:0]  pix_y = '0;
   logic        pix_req;
   logic        pclk;
   logic [7:0]  r_out, g_out, b_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5ns clk = ~clk;

   rgb_pixel_out i_rgb_pixel_out (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_pol(cfg_pol),
      .cfg_spread(cfg_spread), .cfg_dither(cfg_dither), .cfg_width(cfg_width),
      .cfg_swz(cfg_swz), .pix_data(pix_data), .pix_x(pix_x), .pix_y(pix_y),
      .pix_req(pix_req), .pclk(pclk), .r_out(r_out), .g_out(g_out), .b_out(b_out)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_prep(input logic [7:0] v, input logic [2:0] wf,
                                           input bit dith, input int x, input int y);
      int k, d, s;
      k = (wf == 3'd0) ? 8 : int'(wf);
      d = 8 - k;
      s = int'(v);
      if (dith && d > 0) s = s + ((BT[y*4 + x] << d) >> 4);
      if (s > 255) s = 255;
      s = s & ((255 << d) & 255);
      return s[7:0];
   endfunction

   function automatic logic [23:0] exp_pins(input logic [23:0] px, input logic [8:0] wd,
                                            input bit dith, input int x, input int y,
                                            input logic [3:0] sw);
      logic [7:0] a, b, c, t0, pa, pb, pc, ra, rb, rc;
      a = exp_prep(px[23:16], wd[2:0], dith, x, y);
      b = exp_prep(px[15:8],  wd[5:3], dith, x, y);
      c = exp_prep(px[7:0],   wd[8:6], dith, x, y);
      if (sw[1]) begin t0 = a; a = c; c = t0; end
      if (sw[3]) begin
         if (sw[2]) {pa, pb, pc} = {b, c, a};
         else       {pa, pb, pc} = {c, a, b};
      end else {pa, pb, pc} = {a, b, c};
      for (int i = 0; i < 8; i++) begin
         ra[i] = sw[0] ? pa[7-i] : pa[i];
         rb[i] = sw[0] ? pb[7-i] : pb[i];
         rc[i] = sw[0] ? pc[7-i] : pc[i];
      end
      return {ra, rb, rc};
   endfunction

   // entered at a falling edge; returns at the falling edge after acceptance
   task automatic send(input logic [23:0] px, input int x, input int y);
      while (pix_req !== 1'b1) @(negedge clk);
      pix_data = px;
      pix_x = 2'(x);
      pix_y = 2'(y);
      @(negedge clk);
   endtask

   task automatic measure(input int n, output int highs, output int reqs);
      highs = 0;
      reqs = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pclk === 1'b1) highs++;
         if (pix_req === 1'b1) reqs++;
      end
   endtask

   initial begin
      #1ms;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int hi, rq;
      logic [23:0] hold, pins, e;
      logic [23:0] seq [8];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check({r_out, g_out, b_out} == 24'h0, "R2 reset pins", {r_out, g_out, b_out}, 0);
      check(pix_req == 1'b0, "R2 reset req", pix_req, 0);
      check(pclk == 1'b0, "R2 reset pclk", pclk, 0);

      // R2: divisor zero, both polarities
      for (int p = 0; p < 2; p++) begin
         cfg_pol = p[0];
         repeat (2) @(negedge clk);
         measure(20, hi, rq);
         check(hi == (p == 1 ? 20 : 0), "R2 pclk static", hi, p == 1 ? 20 : 0);
         check(rq == 0, "R2 no request", rq, 0);
      end
      cfg_pol = 1'b0;

      // R1 / R3: divisor sweep, high phase and request counts
      for (int d = 2; d <= 9; d++) begin
         for (int p = 0; p < 2; p++) begin
            cfg_div = 10'(d);
            cfg_pol = p[0];
            repeat (12) @(negedge clk);
            measure(d * 6, hi, rq);
            e = (p == 0) ? 24'(6 * ((d + 1) / 2)) : 24'(6 * (d - (d + 1) / 2));
            check(int'(e) == hi, p == 0 ? "R1 pclk high count" : "R3 inverted high count", hi, e);
            check(rq == 6, "R1 request count", rq, 6);
         end
      end
      cfg_div = 10'd1000;
      cfg_pol = 1'b0;
      repeat (5) @(negedge clk);
      measure(3000, hi, rq);
      check(rq == 3, "R1 large divisor requests", rq, 3);
      check(hi == 1500, "R1 large divisor high", hi, 1500);

      // R4: divisor one follows the system clock
      cfg_div = 10'd1;
      for (int p = 0; p < 2; p++) begin
         cfg_pol = p[0];
         repeat (2) @(negedge clk);
         for (int i = 0; i < 4; i++) begin
            check(pclk == p[0], "R4 pclk low phase", pclk, p[0]);
            check(pix_req == 1'b1, "R4 request every cycle", pix_req, 1);
            @(posedge clk);
            #1ns;
            check(pclk == !p[0], "R4 pclk high phase", pclk, !p[0]);
            @(negedge clk);
         end
      end
      cfg_pol = 1'b0;

      // R10 R11 R12: literal swizzle cases
      cfg_div = 10'd2;
      repeat (4) @(negedge clk);
      cfg_swz = 4'b0010; send(24'h112233, 0, 0);
      check({r_out, g_out, b_out} == 24'h332211, "R10 swap", {r_out, g_out, b_out}, 24'h332211);
      cfg_swz = 4'b1000; send(24'h112233, 0, 0);
      check({r_out, g_out, b_out} == 24'h331122, "R11 rotate bit2=0", {r_out, g_out, b_out}, 24'h331122);
      cfg_swz = 4'b1100; send(24'h112233, 0, 0);
      check({r_out, g_out, b_out} == 24'h223311, "R11 rotate bit2=1", {r_out, g_out, b_out}, 24'h223311);
      cfg_swz = 4'b0001; send(24'h01800F, 0, 0);
      check({r_out, g_out, b_out} == 24'h8001F0, "R12 reverse", {r_out, g_out, b_out}, 24'h8001F0);
      cfg_swz = 4'b1011; send(24'h112233, 0, 0);
      check({r_out, g_out, b_out} == 24'h88CC44, "R12 R10 R11 combined", {r_out, g_out, b_out}, 24'h88CC44);

      // R6 R10 R11 R12: all swizzle codes, full width
      for (int s = 0; s < 16; s++) begin
         for (int q = 0; q < 4; q++) begin
            cfg_swz = 4'(s);
            pix_data = 24'hA5_3C_0F ^ 24'(q * 24'h1F2E3D);
            send(pix_data, q, 3 - q);
            e = exp_pins(pix_data, 9'd0, 1'b0, q, 3 - q, 4'(s));
            pins = {r_out, g_out, b_out};
            check(pins == e, "R6 R11 swizzle sweep", pins, e);
         end
      end

      // R8 R9: width fields, dither on and off, every position
      for (int w = 0; w < 8; w++) begin
         for (int dd = 0; dd < 2; dd++) begin
            for (int p = 0; p < 16; p++) begin
               for (int q = 0; q < 3; q++) begin
                  cfg_width = {3'((w + 5) % 8), 3'((w + 3) % 8), 3'(w)};
                  cfg_dither = dd[0];
                  cfg_swz = 4'((w * 3 + p) % 16);
                  case (q)
                     0: hold = 24'hFFFFFF;
                     1: hold = {8'(p * 17), 8'(w * 37 + 5), 8'd250};
                     default: hold = 24'h7F80C3 ^ 24'(p);
                  endcase
                  send(hold, p % 4, p / 4);
                  e = exp_pins(hold, cfg_width, dd[0], p % 4, p / 4, cfg_swz);
                  pins = {r_out, g_out, b_out};
                  check(pins == e, dd ? "R9 dither" : "R8 truncate", pins, e);
               end
            end
         end
      end
      cfg_dither = 1'b0;
      cfg_width = '0;
      cfg_swz = '0;

      // R5: pins hold between requests
      cfg_div = 10'd4;
      repeat (6) @(negedge clk);
      send(24'h123456, 0, 0);
      hold = {r_out, g_out, b_out};
      check(hold == 24'h123456, "R5 accepted", hold, 24'h123456);
      pix_data = 24'hDEAD00;
      for (int i = 0; i < 3; i++) begin
         pins = {r_out, g_out, b_out};
         check(pins == hold, "R5 hold between", pins, hold);
         @(negedge clk);
      end

      // R2: divisor zero ignores pixel data
      cfg_div = 10'd0;
      for (int i = 0; i < 20; i++) begin
         pix_data = 24'(i * 24'h0B0B0B);
         @(negedge clk);
      end
      pins = {r_out, g_out, b_out};
      check(pins == 24'hDEAD00 || pins == hold, "R2 pins kept", pins, hold);

      // R7: staggered output
      cfg_div = 10'd3;
      cfg_spread = 1'b1;
      for (int sc = 0; sc < 2; sc++) begin
         cfg_swz = sc ? 4'b1010 : 4'b0000;
         for (int k = 0; k < 8; k++) begin
            seq[k] = 24'h102030 + 24'(k * 24'h050709) + 24'(sc * 24'h400000);
            send(seq[k], 0, 0);
            if (k >= 2) begin
               e = {exp_pins(seq[k], 9'd0, 1'b0, 0, 0, cfg_swz)[23:16],
                    exp_pins(seq[k-1], 9'd0, 1'b0, 0, 0, cfg_swz)[15:8],
                    exp_pins(seq[k-2], 9'd0, 1'b0, 0, 0, cfg_swz)[7:0]};
               pins = {r_out, g_out, b_out};
               check(pins == e, "R7 stagger", pins, e);
            end
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule